// File: doc/BRIEF.md
# Double-Buffered SPI Transfer Unit

This block moves bytes between an 8-bit register port on the CPU side and a four-wire serial link. A write to the data address lands in a one-byte transmit holding register. The byte moves into the shift register as soon as the shifter is free, so software can queue one byte behind the byte being sent. A completed transfer copies the shifted-in byte into a receive holding register. Status flags report four conditions: transmit holding register empty, receive data waiting, receive overflow and mode fault. One interrupt line combines the receive and error conditions under separate enable bits.

As a master the unit generates SCK at a fixed division of the bus clock and drives MOSI. It also watches the select input so that a conflicting master can be detected. As a slave it follows an external SCK, qualified by an active-low select, and drives MISO. The link uses one timing mode. Data goes MSB first. SCK idles low. Both ends capture on the rising edge and change their output on the falling edge. The overflow check runs partway through the next transfer, not at its end. While an overflow is pending, incoming bytes are dropped. The flag is cleared by a two-step read sequence.

Register map on `bus_addr`:
- 0 is control. Bit 0 enables the unit, bit 1 selects master, bit 2 enables the receive interrupt and bit 3 enables the error interrupt.
- 1 is status, read only. Bit 7 is receive-full, bit 6 is overflow, bit 4 is mode fault and bit 3 is transmit-empty. All other bits read 0.
- 2 is data. A write goes to the transmit holding register and a read returns the receive holding register.

Top module: `spi_dbuf_unit`

## Requirements
- R1: After reset, status reads 0x08 (only transmit-empty set), `irq` is low, and `sck_oe`, `mosi_oe` and `miso_oe` are low.
- R2: When an enabled, idle master has its data register written, the byte moves into the shift register and status bit 3 (transmit-empty) reads 1 again no later than the second clock edge after the write edge.
- R3: A master shifts MSB first on `mosi_o`. The period of `sck_o` is 2*HALF_DIV bus clocks (4 by default). MISO is captured on each rising SCK edge. After eight bits the captured byte appears at data address 2, and status bit 7 (receive-full) is set.
- R4: While a transfer is in progress and another byte waits in the transmit holding register, transmit-empty stays 0. The waiting byte is not loaded until the current transfer has finished.
- R5: A data write made while transmit-empty is 0 is ignored. The pending byte is not replaced and no extra transfer results.
- R6: Overflow (status bit 6) becomes 1 at the 7th rising SCK edge of a transfer if receive-full is still set at that moment, and not before that edge.
- R7: While overflow is set, completed transfers neither update the receive holding register nor set receive-full. The byte received before the overflow remains readable.
- R8: Overflow drives `irq` high only when control bit 3 (error interrupt enable) is set.
- R9: Overflow clears only when a status read made while the flag is set is followed by a data read. A data read alone leaves it set.
- R10: With control bit 2 set, `irq` is high while receive-full is set. A data read clears receive-full.
- R11: A low level on `ss_n_i` while the unit is an enabled master sets mode fault (status bit 4). It turns off `sck_oe` and `mosi_oe` and abandons the transfer in progress, which produces no received byte. Mode fault clears only when a status read made while the flag is set is followed by a control write.
- R12: An enabled slave selected by `ss_n_i` low shifts out a preloaded byte on `miso_o` (with `miso_oe` high) and receives the byte on `mosi_i`, using the same edge rules as R3 on an external `sck_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while `bus_sel` is high and `bus_wr` is low |
| irq | output | 1 | Receive / error interrupt request |
| sck_o | output | 1 | Master serial clock |
| sck_oe | output | 1 | Enable for the `sck_o` driver |
| mosi_o | output | 1 | Master serial data out |
| mosi_oe | output | 1 | Enable for the `mosi_o` driver |
| miso_i | input | 1 | Master serial data in |
| sck_i | input | 1 | Slave serial clock in |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Enable for the `miso_o` driver |
| ss_n_i | input | 1 | Slave select in; mode-fault sense as a master |

## Verification
The hardest condition to reach from the ports is an overflow at the exact capture of bit 1 while an earlier byte sits unread. Exactly one queued byte must start right after the first, and the status register must stay unread at the moment that matters. The bench writes two bytes back to back and loops MOSI into MISO. It counts rising edges on `sck_o` and samples status after the 14th and the 15th rise, so it sees the flag stay low and then go high. It then waits without reading status, to show that a data read alone leaves overflow set, and checks that the byte held in the receive register is still the first one.

// File: rtl/spi_dbuf_pkg.sv
// Package: shared register addresses, control/status bit positions and
// bus geometry for the double-buffered SPI transfer unit.
// Assumes an 8-bit or wider data bus so that every status bit fits.
package spi_dbuf_pkg;
    localparam int unsigned AW = 2;

    localparam logic [AW-1:0] ADR_CTRL = 2'd0;
    localparam logic [AW-1:0] ADR_STAT = 2'd1;
    localparam logic [AW-1:0] ADR_DATA = 2'd2;

    // control bits
    localparam int unsigned C_EN  = 0;
    localparam int unsigned C_MST = 1;
    localparam int unsigned C_RIE = 2;
    localparam int unsigned C_EIE = 3;

    // status bits
    localparam int unsigned S_RXF  = 7;
    localparam int unsigned S_OVR  = 6;
    localparam int unsigned S_MODF = 4;
    localparam int unsigned S_TXE  = 3;
endpackage

// File: rtl/spi_edge_gen.sv
// Module: spi_edge_gen
// Produces one-cycle capture (rising SCK) and shift (falling SCK) strobes.
// As master it divides the bus clock by 2*HALF while run is high and holds
// SCK low otherwise. As slave it synchronises an external SCK with two
// flops and detects its edges. Assumes the external SCK is slow compared
// with the bus clock (at least a few bus cycles per level).
module spi_edge_gen #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic run,
    input  logic sck_ext,
    output logic cap_p,
    output logic shf_p,
    output logic sck_lvl
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          lvl;
    logic [2:0]    sync;
    logic          tick;

    assign tick    = (cnt == CW'(HALF - 1));
    assign sck_lvl = lvl;

    // Purpose: master half-period counter and SCK level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (!(master && run)) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            lvl <= ~lvl;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Purpose: bring the external slave clock into the bus clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= '0;
        else        sync <= {sync[1:0], sck_ext};
    end

    // Purpose: choose the strobe source for the configured role.
    always_comb begin
        if (master) begin
            cap_p = run && tick && !lvl;
            shf_p = run && tick && lvl;
        end else begin
            cap_p = sync[1] && !sync[2];
            shf_p = !sync[1] && sync[2];
        end
    end
endmodule

// File: rtl/spi_shift.sv
// Module: spi_shift
// Eight-bit (W-bit) shift engine. Loads from the transmit holding register
// only while not busy, captures the input bit on cap_p and shifts it in MSB
// first on shf_p. Flags the capture of bit 1 and the completion of a frame.
// kill drops the frame in progress. Assumes cap_p and shf_p alternate.
module spi_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         master,
    input  logic         slave_sel,
    input  logic         load_ok,
    input  logic         kill,
    input  logic         ld_req,
    input  logic [W-1:0] ld_data,
    input  logic         cap_p,
    input  logic         shf_p,
    input  logic         sdi,
    output logic         ld_ack,
    output logic         busy,
    output logic         sdo,
    output logic         bit1_stb,
    output logic         done,
    output logic [W-1:0] rx_data
);
    localparam int unsigned BCW = $clog2(W);

    logic [W-1:0]   shreg;
    logic [BCW-1:0] bitn;
    logic           rbit;
    logic           busy_q;
    logic           cap_ok;
    logic           last;

    assign ld_ack   = !busy_q && ld_req && load_ok;
    assign cap_ok   = cap_p && !kill && (master ? busy_q : slave_sel);
    assign last     = (bitn == BCW'(W - 1));
    assign done     = shf_p && busy_q && !kill && last;
    assign bit1_stb = cap_ok && (bitn == BCW'(W - 2));
    assign rx_data  = {shreg[W-2:0], rbit};
    assign sdo      = shreg[W-1];
    assign busy     = busy_q;

    // Purpose: frame state, bit counter, capture latch and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitn   <= '0;
            rbit   <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (ld_ack) shreg <= ld_data;
            if (kill) begin
                busy_q <= 1'b0;
                bitn   <= '0;
            end else begin
                if (ld_ack && master) busy_q <= 1'b1;
                if (cap_ok) begin
                    rbit <= sdi;
                    if (!master) busy_q <= 1'b1;
                end
                if (shf_p && busy_q) begin
                    shreg <= {shreg[W-2:0], rbit};
                    if (last) begin
                        bitn   <= '0;
                        busy_q <= 1'b0;
                    end else begin
                        bitn <= bitn + BCW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_regs.sv
// Module: spi_regs
// CPU-side register file. Holds control, the transmit holding register and
// the receive holding register. Keeps the receive-full, overflow and
// mode-fault flags with their two-step clear sequences, and forms the
// interrupt. Assumes one-cycle bus_sel strobes; read side effects occur on
// the strobe cycle.
module spi_regs
    import spi_dbuf_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ld_ack,
    input  logic          bit1_stb,
    input  logic          done,
    input  logic [DW-1:0] rx_data,
    input  logic          modf_det,
    output logic          ctl_en,
    output logic          ctl_master,
    output logic          modf,
    output logic          txfull,
    output logic [DW-1:0] txbuf,
    output logic          irq
);
    logic [DW-1:0] ctrl;
    logic [DW-1:0] rxbuf;
    logic          rxf, ovr, ovr_arm, modf_arm;
    logic          rd_stat, rd_data, wr_ctrl, wr_data;

    assign rd_stat = bus_sel && !bus_wr && (bus_addr == ADR_STAT);
    assign rd_data = bus_sel && !bus_wr && (bus_addr == ADR_DATA);
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADR_CTRL);
    assign wr_data = bus_sel && bus_wr && (bus_addr == ADR_DATA);

    assign ctl_en     = ctrl[C_EN];
    assign ctl_master = ctrl[C_MST];
    assign irq        = (rxf && ctrl[C_RIE]) || ((ovr || modf) && ctrl[C_EIE]);

    // Purpose: control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= bus_wdata;
    end

    // Purpose: transmit holding register; writes accepted only when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txbuf  <= '0;
            txfull <= 1'b0;
        end else begin
            if (ld_ack) txfull <= 1'b0;
            if (wr_data && !txfull) begin
                txbuf  <= bus_wdata;
                txfull <= 1'b1;
            end
        end
    end

    // Purpose: receive holding register and receive-full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxbuf <= '0;
            rxf   <= 1'b0;
        end else if (done && !ovr) begin
            rxbuf <= rx_data;
            rxf   <= 1'b1;
        end else if (rd_data) begin
            rxf <= 1'b0;
        end
    end

    // Purpose: overflow flag with status-then-data clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr     <= 1'b0;
            ovr_arm <= 1'b0;
        end else begin
            if (bit1_stb && rxf)         ovr <= 1'b1;
            else if (rd_data && ovr_arm) ovr <= 1'b0;
            if (!ovr)                    ovr_arm <= 1'b0;
            else if (rd_stat)            ovr_arm <= 1'b1;
        end
    end

    // Purpose: mode-fault flag with status-then-control-write clear sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modf     <= 1'b0;
            modf_arm <= 1'b0;
        end else begin
            if (modf_det)                 modf <= 1'b1;
            else if (wr_ctrl && modf_arm) modf <= 1'b0;
            if (!modf)                    modf_arm <= 1'b0;
            else if (rd_stat)             modf_arm <= 1'b1;
        end
    end

    // Purpose: read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTRL: bus_rdata = ctrl;
            ADR_STAT: begin
                bus_rdata[S_RXF]  = rxf;
                bus_rdata[S_OVR]  = ovr;
                bus_rdata[S_MODF] = modf;
                bus_rdata[S_TXE]  = !txfull;
            end
            ADR_DATA: bus_rdata = rxbuf;
            default:  bus_rdata = '0;
        endcase
    end

    a_r6_ovr_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(rxf));
    a_r7_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && done) |=> $stable(rxbuf));
    a_r9_ovr_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr) |-> $past(rd_data));
endmodule

// File: rtl/spi_dbuf_unit.sv
// Module: spi_dbuf_unit (top)
// Double-buffered SPI transfer unit. Ties together the register file, the
// shift engine and the SCK edge generator. Synchronises the select input,
// detects a mode fault in master mode and drives the pad enables.
// Assumes external serial inputs change slowly relative to clk in slave mode.
module spi_dbuf_unit
    import spi_dbuf_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned HALF_DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          sck_o,
    output logic          sck_oe,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    input  logic          sck_i,
    input  logic          mosi_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i
);
    logic          ctl_en, ctl_master, modf_flag, txfull;
    logic          ld_ack, sh_busy, bit1_stb, done, sdo;
    logic          cap_p, shf_p, sck_lvl;
    logic          ss_low, modf_det, kill, load_ok, slave_sel, sdi;
    logic [DW-1:0] txbuf, rx_data;
    logic [1:0]    ss_sync;

    // Purpose: two-flop synchroniser for the select input (idles high).
    always_ff @(posedge clk) begin
        if (!rst_n) ss_sync <= 2'b11;
        else        ss_sync <= {ss_sync[0], ss_n_i};
    end

    assign ss_low    = !ss_sync[1];
    assign modf_det  = ctl_en && ctl_master && ss_low;
    assign kill      = !ctl_en || (ctl_master ? (modf_flag || modf_det) : !ss_low);
    assign load_ok   = ctl_en && (!ctl_master || !(modf_flag || modf_det));
    assign slave_sel = ctl_en && !ctl_master && ss_low;
    assign sdi       = ctl_master ? miso_i : mosi_i;

    assign sck_o   = sck_lvl;
    assign sck_oe  = ctl_en && ctl_master && !modf_flag;
    assign mosi_o  = sdo;
    assign mosi_oe = ctl_en && ctl_master && !modf_flag;
    assign miso_o  = sdo;
    assign miso_oe = slave_sel;

    spi_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ld_ack(ld_ack), .bit1_stb(bit1_stb), .done(done), .rx_data(rx_data),
        .modf_det(modf_det), .ctl_en(ctl_en), .ctl_master(ctl_master),
        .modf(modf_flag), .txfull(txfull), .txbuf(txbuf), .irq(irq)
    );

    spi_shift #(.W(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .master(ctl_master), .slave_sel(slave_sel),
        .load_ok(load_ok), .kill(kill), .ld_req(txfull), .ld_data(txbuf),
        .cap_p(cap_p), .shf_p(shf_p), .sdi(sdi),
        .ld_ack(ld_ack), .busy(sh_busy), .sdo(sdo), .bit1_stb(bit1_stb),
        .done(done), .rx_data(rx_data)
    );

    spi_edge_gen #(.HALF(HALF_DIV)) u_edge (
        .clk(clk), .rst_n(rst_n), .master(ctl_master), .run(sh_busy),
        .sck_ext(sck_i), .cap_p(cap_p), .shf_p(shf_p), .sck_lvl(sck_lvl)
    );

    a_r2_refill: assert property (@(posedge clk) disable iff (!rst_n)
        (txfull && !sh_busy && load_ok) |=> !txfull);
    a_r4_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (txfull && sh_busy && !done) |=> txfull);
    a_r11_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
        modf_flag |=> !sh_busy);
endmodule

// File: tb/sim_spi_dbuf_unit.sv
`timescale 1ns/1ps
module sim_spi_dbuf_unit;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [7:0] EN = 8'h01, MST = 8'h02, RIE = 8'h04, EIE = 8'h08;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic miso_i;
    logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;
    assign miso_i = mosi_o;

    spi_dbuf_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
        .mosi_oe(mosi_oe), .miso_i(miso_i), .sck_i(sck_i), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // driver: queue a byte for transmission and record the looped-back result
    task automatic send(input logic [7:0] d);
        bus_write(A_DATA, d);
        exp_q.push_back(d);
    endtask

    // monitor: wait for receive-full, read the byte, compare with scoreboard
    task automatic monitor_pop(input string tag);
        logic [7:0] s, d, e;
        int guard;
        s = '0; guard = 0;
        while (!s[7] && guard < 300) begin
            bus_read(A_STAT, s);
            guard++;
        end
        bus_read(A_DATA, d);
        if (exp_q.size() == 0) chk({tag, " queue empty"}, 32'd1, 32'd0);
        else begin
            e = exp_q.pop_front();
            chk(tag, {24'd0, d}, {24'd0, e});
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [7:0] s, d, cap;
        realtime t0, t1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(A_STAT, s);
        chk("R1 status after reset", {24'd0, s}, 32'h08);
        chk("R1 irq low", {31'd0, irq}, 32'd0);
        chk("R1 drivers off", {29'd0, sck_oe, mosi_oe, miso_oe}, 32'd0);

        bus_write(A_CTRL, EN | MST);

        // R2 / R3: first byte, timing and bit order
        bus_write(A_DATA, 8'hA5);
        exp_q.push_back(8'hA5);
        bus_read(A_STAT, s);
        chk("R2 txe back within two edges", {31'd0, s[3]}, 32'd1);
        cap = '0; t0 = 0; t1 = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge sck_o);
            if (i == 0) t0 = $realtime;
            if (i == 1) t1 = $realtime;
            cap = {cap[6:0], mosi_o};
        end
        chk("R3 msb-first on mosi", {24'd0, cap}, 32'hA5);
        chk("R3 sck period ns", int'(t1 - t0), 32'd20);
        monitor_pop("R3 loopback A5");
        send(8'h3C); monitor_pop("R3 loopback 3C");
        send(8'hFF); monitor_pop("R3 loopback FF");
        send(8'h00); monitor_pop("R3 loopback 00");

        // R4 / R5: queue behind active byte, write while full ignored
        send(8'h11);
        send(8'h22);
        bus_read(A_STAT, s);
        chk("R4 txe low while byte queued", {31'd0, s[3]}, 32'd0);
        bus_write(A_DATA, 8'h33);
        monitor_pop("R4 first of pair");
        monitor_pop("R5 queued byte not replaced");
        wait_clk(60);
        bus_read(A_STAT, s);
        chk("R5 no extra transfer (rxf)", {31'd0, s[7]}, 32'd0);
        chk("R4 txe after drain", {31'd0, s[3]}, 32'd1);

        // R6: overflow timing with two back-to-back bytes left unread
        bus_write(A_DATA, 8'h81);
        bus_write(A_DATA, 8'h7E);
        repeat (14) @(posedge sck_o);
        bus_read(A_STAT, s);
        chk("R6 no overflow before bit-1 strobe", {31'd0, s[6]}, 32'd0);
        @(posedge sck_o);
        bus_read(A_STAT, s);
        chk("R6 overflow at 7th rise", {31'd0, s[6]}, 32'd1);
        wait_clk(30);
        chk("R8 irq off without error enable", {31'd0, irq}, 32'd0);
        bus_write(A_CTRL, EN | MST | EIE);
        chk("R8 irq on with error enable", {31'd0, irq}, 32'd1);
        bus_read(A_DATA, d);
        chk("R7 earlier byte preserved", {24'd0, d}, 32'h81);
        bus_read(A_STAT, s);
        chk("R9 status+data clears overflow", {31'd0, s[6]}, 32'd0);
        chk("R7 second byte discarded", {31'd0, s[7]}, 32'd0);

        // R9: data read alone leaves overflow set
        bus_write(A_DATA, 8'h5C);
        wait_clk(50);
        bus_write(A_DATA, 8'hC5);
        wait_clk(50);
        bus_read(A_DATA, d);
        chk("R7 first byte kept (second run)", {24'd0, d}, 32'h5C);
        bus_read(A_STAT, s);
        chk("R9 data read alone keeps overflow", {31'd0, s[6]}, 32'd1);
        bus_read(A_DATA, d);
        chk("R7 discarded byte not copied", {24'd0, d}, 32'h5C);
        bus_read(A_STAT, s);
        chk("R9 cleared after sequence", {31'd0, s[6]}, 32'd0);

        // R10: receive interrupt
        bus_write(A_CTRL, EN | MST | RIE);
        send(8'h6E);
        for (int i = 0; i < 80 && !irq; i++) @(negedge clk);
        chk("R10 irq on receive-full", {31'd0, irq}, 32'd1);
        bus_read(A_DATA, d);
        chk("R10 received byte", {24'd0, d}, {24'd0, exp_q.pop_front()});
        chk("R10 data read clears irq", {31'd0, irq}, 32'd0);

        // R11: mode fault mid-transfer
        bus_write(A_DATA, 8'h99);
        repeat (3) @(posedge sck_o);
        ss_n_i = 1'b0;
        wait_clk(6);
        chk("R11 drivers off on fault", {30'd0, sck_oe, mosi_oe}, 32'd0);
        ss_n_i = 1'b1;
        wait_clk(4);
        bus_write(A_CTRL, EN | MST);
        bus_read(A_STAT, s);
        chk("R11 write alone keeps fault", {31'd0, s[4]}, 32'd1);
        bus_write(A_CTRL, EN | MST);
        bus_read(A_STAT, s);
        chk("R11 status+write clears fault", {31'd0, s[4]}, 32'd0);
        chk("R11 sck driver back", {31'd0, sck_oe}, 32'd1);
        wait_clk(60);
        bus_read(A_STAT, s);
        chk("R11 abandoned byte not received", {31'd0, s[7]}, 32'd0);

        // R12: slave transfer driven by the bench as master
        bus_write(A_CTRL, EN);
        bus_write(A_DATA, 8'h96);
        wait_clk(2);
        ss_n_i = 1'b0;
        wait_clk(4);
        chk("R12 miso driver on when selected", {31'd0, miso_oe}, 32'd1);
        cap = '0;
        for (int i = 7; i >= 0; i--) begin
            mosi_i = 8'h5A >> i;
            wait_clk(8);
            cap = {cap[6:0], miso_o};
            sck_i = 1'b1;
            wait_clk(8);
            sck_i = 1'b0;
        end
        wait_clk(8);
        ss_n_i = 1'b1;
        chk("R12 slave shifted out preload", {24'd0, cap}, 32'h96);
        bus_read(A_STAT, s);
        chk("R12 slave receive-full", {31'd0, s[7]}, 32'd1);
        bus_read(A_DATA, d);
        chk("R12 slave received byte", {24'd0, d}, 32'h5A);

        summary();
    end
endmodule